// File: doc/BRIEF.md
# Virtualization-aware interrupt arbiter

This block sits beside a processor core and decides, every cycle, whether the core should take an exception and which class it is. It handles physical and virtual sources.

The physical sources are IRQ, FIQ, asynchronous abort, reset and send-event. Each of them is held in a pending latch, and so are the latched virtual IRQ and FIQ lines. A hypervisor can also inject a virtual IRQ, FIQ or abort through three request bits.

Virtual classes reach the core only outside hypervisor mode and outside secure state, and each one needs its own routing bit. The decision outputs come straight from the latch contents and the live control inputs, with no register in between. They are:
- a take flag and a one-hot class select,
- a wait-for-interrupt wake signal that ignores the masks,
- a 32-bit status word laid out like the program status register.

The core acknowledges the class it took by returning the one-hot select as a one-cycle pulse. That pulse clears the matching latch.

Top module: `virt_irq_arbiter`

## Requirements
- R1: Class encoding, one bit per class: bit0 physical IRQ, bit1 virtual IRQ, bit2 physical FIQ, bit3 virtual FIQ, bit4 physical abort, bit5 virtual abort, bit6 reset, bit7 send-event. A one-cycle pulse on set bit k sets latch k, and a one-cycle pulse on ack bit k clears it. When set and ack reach the same latch in the same cycle, the latch ends up set. Bit5 of the set input has no effect, because there is no virtual abort latch.
- R2: While reset is active and after it is released, every latch reads clear. With the hypervisor request bits low, take, select, wake and status are then all zero.
- R3: A physical IRQ (bit0), FIQ (bit2) or abort (bit4) can be taken when its latch is set and its mask bit (I, F or A) is clear.
- R4: A virtual IRQ can be taken only when all of these hold: I is clear, the IRQ routing bit is set, the core is not in secure state and the core is not in hypervisor mode. Virtual FIQ follows the same rule with F and its routing bit, and virtual abort with A and its routing bit.
- R5: A virtual IRQ or FIQ is pending when its latch or its hypervisor request bit is set. A virtual abort is pending only when its hypervisor request bit is set.
- R6: Among the classes that can be taken, the select output is one-hot on the lowest bit index of the R1 encoding. The take output is high exactly when some class can be taken.
- R7: Reset (bit6) and send-event (bit7) can be taken whenever their latch is set, whatever the masks say.
- R8: Wake is high whenever any physical latch (bits 0, 2, 4, 6, 7) is set, whatever the masks say. The virtual IRQ and FIQ latches do not feed this physical term.
- R9: Wake is also high when some virtual class is pending and its routing bit is set, whatever the masks say. This holds only outside hypervisor mode and outside secure state.
- R10: The status word carries A at bit 8, I at bit 7 and F at bit 6, and all its other bits are zero. A status bit shows the virtual pending value of its class when that class is routed (routing bit set, not hypervisor mode, not secure). Otherwise it shows the physical latch of that class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| set_i | input | 8 | Per-class latch set pulses (R1 encoding) |
| ack_i | input | 8 | One-hot acknowledge pulse clearing a latch |
| hyp_vi_i | input | 1 | Hypervisor-injected virtual IRQ |
| hyp_vf_i | input | 1 | Hypervisor-injected virtual FIQ |
| hyp_va_i | input | 1 | Hypervisor-injected virtual abort |
| mask_irq_i | input | 1 | I mask bit |
| mask_fiq_i | input | 1 | F mask bit |
| mask_abt_i | input | 1 | A mask bit |
| route_irq_i | input | 1 | IRQ routing to virtual |
| route_fiq_i | input | 1 | FIQ routing to virtual |
| route_abt_i | input | 1 | Abort routing to virtual |
| hyp_mode_i | input | 1 | Core in hypervisor mode |
| secure_i | input | 1 | Core in secure state |
| take_o | output | 1 | An exception should be taken |
| sel_o | output | 8 | One-hot selected class |
| wake_o | output | 1 | Wait-for-interrupt wake |
| status_o | output | 32 | Interrupt status word |

## Verification
The bench loads each of the 128 latch patterns that leave the virtual abort bit clear. For every pattern it applies all 2048 combinations of masks, routing bits, mode, security and hypervisor request bits. Together these separate three effects: routing gated by mode and security, a hypervisor request bit against a latched virtual line, and priority between neighbouring physical and virtual classes. They also show that wake ignores every mask while the take output obeys them. Directed sequences then acknowledge classes in turn through the select output, collide a set with an acknowledge on the same latch, and show that a set on the virtual abort bit leaves every output at zero.

// File: rtl/virt_irq_pkg.sv
package virt_irq_pkg;
  localparam int NUM_CLS = 8;
  localparam int CLS_PIRQ = 0;
  localparam int CLS_VIRQ = 1;
  localparam int CLS_PFIQ = 2;
  localparam int CLS_VFIQ = 3;
  localparam int CLS_PABT = 4;
  localparam int CLS_VABT = 5;
  localparam int CLS_RST  = 6;
  localparam int CLS_SEV  = 7;

  localparam logic [NUM_CLS-1:0] LATCH_MASK = 8'b1101_1111;
  localparam logic [NUM_CLS-1:0] PHYS_MASK  = 8'b1101_0101;

  typedef struct packed {
    logic abt;
    logic irq;
    logic fiq;
  } trio_t;
endpackage

// File: rtl/pend_bank.sv
module pend_bank
  import virt_irq_pkg::*;
#(
  parameter int N = NUM_CLS,
  parameter logic [N-1:0] HAS_LATCH = LATCH_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] pend_o
);
  for (genvar k = 0; k < N; k++) begin : g_cls
    if (HAS_LATCH[k]) begin : g_lat
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       q <= 1'b0;
        else if (set_i[k]) q <= 1'b1;
        else if (ack_i[k]) q <= 1'b0;
      end
      assign pend_o[k] = q;

      // R1
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] |=> pend_o[k]);
      // R1
      ack_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i[k] && !set_i[k]) |=> !pend_o[k]);
    end else begin : g_none
      assign pend_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/cls_qualify.sv
module cls_qualify
  import virt_irq_pkg::*;
(
  input  logic [NUM_CLS-1:0] pend_i,
  input  trio_t              mask_i,
  input  trio_t              route_i,
  input  trio_t              hyp_req_i,
  input  logic               hyp_mode_i,
  input  logic               secure_i,
  output trio_t              vpend_o,
  output trio_t              routed_o,
  output logic [NUM_CLS-1:0] takeable_o
);
  logic virt_ok;
  assign virt_ok = !hyp_mode_i && !secure_i;

  assign vpend_o.irq = pend_i[CLS_VIRQ] | hyp_req_i.irq;
  assign vpend_o.fiq = pend_i[CLS_VFIQ] | hyp_req_i.fiq;
  assign vpend_o.abt = hyp_req_i.abt;

  assign routed_o.irq = route_i.irq & virt_ok;
  assign routed_o.fiq = route_i.fiq & virt_ok;
  assign routed_o.abt = route_i.abt & virt_ok;

  always_comb begin
    takeable_o           = '0;
    takeable_o[CLS_PIRQ] = pend_i[CLS_PIRQ] & !mask_i.irq;
    takeable_o[CLS_VIRQ] = vpend_o.irq & routed_o.irq & !mask_i.irq;
    takeable_o[CLS_PFIQ] = pend_i[CLS_PFIQ] & !mask_i.fiq;
    takeable_o[CLS_VFIQ] = vpend_o.fiq & routed_o.fiq & !mask_i.fiq;
    takeable_o[CLS_PABT] = pend_i[CLS_PABT] & !mask_i.abt;
    takeable_o[CLS_VABT] = vpend_o.abt & routed_o.abt & !mask_i.abt;
    takeable_o[CLS_RST]  = pend_i[CLS_RST];
    takeable_o[CLS_SEV]  = pend_i[CLS_SEV];
  end

  // R7
  rst_unmasked_chk: assert final (!pend_i[CLS_RST] || takeable_o[CLS_RST]);
endmodule

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] sel_o,
  output logic         any_o
);
  logic hit;
  always_comb begin
    sel_o = '0;
    hit   = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (req_i[k] && !hit) begin
        sel_o[k] = 1'b1;
        hit      = 1'b1;
      end
    end
  end
  assign any_o = |req_i;

  // R6
  sel_onehot_chk: assert final ($onehot0(sel_o) && ((sel_o != '0) == any_o));
endmodule

// File: rtl/wake_status.sv
module wake_status
  import virt_irq_pkg::*;
#(
  parameter int STATUS_W = 32,
  parameter int A_POS    = 8,
  parameter int I_POS    = 7,
  parameter int F_POS    = 6
) (
  input  logic [NUM_CLS-1:0]  pend_i,
  input  trio_t               vpend_i,
  input  trio_t               routed_i,
  output logic                wake_o,
  output logic [STATUS_W-1:0] status_o
);
  logic phys_wake, virt_wake;

  assign phys_wake = |(pend_i & PHYS_MASK);
  assign virt_wake = (vpend_i.irq & routed_i.irq) |
                     (vpend_i.fiq & routed_i.fiq) |
                     (vpend_i.abt & routed_i.abt);
  assign wake_o = phys_wake | virt_wake;

  always_comb begin
    status_o        = '0;
    status_o[I_POS] = routed_i.irq ? vpend_i.irq : pend_i[CLS_PIRQ];
    status_o[F_POS] = routed_i.fiq ? vpend_i.fiq : pend_i[CLS_PFIQ];
    status_o[A_POS] = routed_i.abt ? vpend_i.abt : pend_i[CLS_PABT];
  end
endmodule

// File: rtl/virt_irq_arbiter.sv
module virt_irq_arbiter
  import virt_irq_pkg::*;
#(
  parameter int STATUS_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CLS-1:0]  set_i,
  input  logic [NUM_CLS-1:0]  ack_i,
  input  logic                hyp_vi_i,
  input  logic                hyp_vf_i,
  input  logic                hyp_va_i,
  input  logic                mask_irq_i,
  input  logic                mask_fiq_i,
  input  logic                mask_abt_i,
  input  logic                route_irq_i,
  input  logic                route_fiq_i,
  input  logic                route_abt_i,
  input  logic                hyp_mode_i,
  input  logic                secure_i,
  output logic                take_o,
  output logic [NUM_CLS-1:0]  sel_o,
  output logic                wake_o,
  output logic [STATUS_W-1:0] status_o
);
  logic [NUM_CLS-1:0] pend, takeable;
  trio_t mask, route, hyp_req, vpend, routed;

  assign mask    = '{abt: mask_abt_i,  irq: mask_irq_i,  fiq: mask_fiq_i};
  assign route   = '{abt: route_abt_i, irq: route_irq_i, fiq: route_fiq_i};
  assign hyp_req = '{abt: hyp_va_i,    irq: hyp_vi_i,    fiq: hyp_vf_i};

  pend_bank #(.N(NUM_CLS), .HAS_LATCH(LATCH_MASK)) u_pend (
    .clk_i, .rst_ni, .set_i, .ack_i, .pend_o(pend)
  );

  cls_qualify u_qual (
    .pend_i(pend), .mask_i(mask), .route_i(route), .hyp_req_i(hyp_req),
    .hyp_mode_i, .secure_i, .vpend_o(vpend), .routed_o(routed),
    .takeable_o(takeable)
  );

  prio_pick #(.N(NUM_CLS)) u_prio (
    .req_i(takeable), .sel_o(sel_o), .any_o(take_o)
  );

  wake_status #(.STATUS_W(STATUS_W)) u_ws (
    .pend_i(pend), .vpend_i(vpend), .routed_i(routed),
    .wake_o(wake_o), .status_o(status_o)
  );

  // R4
  virt_irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[CLS_VIRQ] |-> (!hyp_mode_i && !secure_i && route_irq_i && !mask_irq_i));
  // R4
  virt_abt_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_o[CLS_VABT] |-> (!hyp_mode_i && !secure_i && route_abt_i && !mask_abt_i));
  // R9
  take_wakes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> wake_o);
  // R3
  masked_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_irq_i |-> !(sel_o[CLS_PIRQ] || sel_o[CLS_VIRQ]));
endmodule

// File: tb/virt_irq_arbiter_bench.sv
`timescale 1ns/100ps
module virt_irq_arbiter_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [7:0] set_v = '0, ack_v = '0;
  logic [10:0] ctl = '0;
  logic take;
  logic [7:0] sel;
  logic wake;
  logic [31:0] status;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  virt_irq_arbiter u_virt_irq_arbiter (
    .clk_i(clk), .rst_ni(rst_n), .set_i(set_v), .ack_i(ack_v),
    .hyp_vi_i(ctl[8]), .hyp_vf_i(ctl[9]), .hyp_va_i(ctl[10]),
    .mask_irq_i(ctl[0]), .mask_fiq_i(ctl[1]), .mask_abt_i(ctl[2]),
    .route_irq_i(ctl[3]), .route_fiq_i(ctl[4]), .route_abt_i(ctl[5]),
    .hyp_mode_i(ctl[6]), .secure_i(ctl[7]),
    .take_o(take), .sel_o(sel), .wake_o(wake), .status_o(status)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // ctl: 0 mI,1 mF,2 mA,3 rI,4 rF,5 rA,6 hyp,7 sec,8 vi,9 vf,10 va
  task automatic model(input logic [7:0] p, input logic [10:0] c,
                       output logic t, output logic [7:0] s,
                       output logic w, output logic [31:0] st);
    logic ok, vip, vfp, vap;
    logic [7:0] tk;
    ok  = !c[6] && !c[7];
    vip = p[1] | c[8];
    vfp = p[3] | c[9];
    vap = c[10];
    tk[0] = p[0] & !c[0];
    tk[1] = vip & !c[0] & c[3] & ok;
    tk[2] = p[2] & !c[1];
    tk[3] = vfp & !c[1] & c[4] & ok;
    tk[4] = p[4] & !c[2];
    tk[5] = vap & !c[2] & c[5] & ok;
    tk[6] = p[6];
    tk[7] = p[7];
    s = tk & (~tk + 8'd1);
    t = |tk;
    w = (p[0] | p[2] | p[4] | p[6] | p[7]) |
        (ok & ((vip & c[3]) | (vfp & c[4]) | (vap & c[5])));
    st = '0;
    st[7] = (ok & c[3]) ? vip : p[0];
    st[6] = (ok & c[4]) ? vfp : p[2];
    st[8] = (ok & c[5]) ? vap : p[4];
  endtask

  task automatic reload(input logic [7:0] p);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; set_v = p;
    @(negedge clk); set_v = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic et, ew;
    logic [7:0] es;
    logic [31:0] est;
    string tg;
    // R2 reset state
    #1;
    chk("R2", "take in reset", {31'd0, take}, 32'd0);
    chk("R2", "sel in reset", {24'd0, sel}, 32'd0);
    chk("R2", "wake in reset", {31'd0, wake}, 32'd0);
    chk("R2", "status in reset", status, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R2", "take after reset", {31'd0, take}, 32'd0);
    chk("R2", "wake after reset", {31'd0, wake}, 32'd0);

    for (int pi = 0; pi < 256; pi++) begin
      if (pi[5]) continue;
      reload(pi[7:0]);
      for (int ci = 0; ci < 2048; ci++) begin
        ctl = ci[10:0];
        #1;
        model(pi[7:0], ci[10:0], et, es, ew, est);
        if (es[0] | es[2] | es[4]) tg = "R3";
        else if (es[1] | es[3] | es[5]) tg = "R4";
        else if (es[6] | es[7]) tg = "R7";
        else tg = "R6";
        chk(tg, "take", {31'd0, take}, {31'd0, et});
        chk(tg, "sel", {24'd0, sel}, {24'd0, es});
        chk(((pi[7:0] & 8'hD5) != 0) ? "R8" : "R9", "wake",
            {31'd0, wake}, {31'd0, ew});
        chk("R10", "status", status, est);
      end
      ctl = '0;
    end

    // R5 virtual abort from hypervisor bit only
    reload(8'h00);
    ctl = 11'b100_0010_0000;
    #1;
    chk("R5", "hyp abort sel", {24'd0, sel}, 32'h20);

    // R1 ack sequence through the select output
    ctl = '0;
    reload(8'b0000_0101);
    chk("R1", "first sel", {24'd0, sel}, 32'h01);
    ack_v = sel; @(negedge clk); ack_v = '0;
    chk("R1", "after ack irq", {24'd0, sel}, 32'h04);
    ack_v = sel; @(negedge clk); ack_v = '0;
    chk("R1", "after ack fiq take", {31'd0, take}, 32'd0);
    chk("R1", "after ack fiq wake", {31'd0, wake}, 32'd0);
    // R1 set wins over ack
    set_v = 8'h01; ack_v = 8'h01; @(negedge clk); set_v = '0; ack_v = '0;
    chk("R1", "set wins", {24'd0, sel}, 32'h01);
    // R1 set on bit5 ignored
    reload(8'h20);
    ctl = 11'b000_0011_1000;
    #1;
    chk("R1", "bit5 take", {31'd0, take}, 32'd0);
    chk("R1", "bit5 wake", {31'd0, wake}, 32'd0);
    chk("R1", "bit5 status", status, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule